// File: doc/BRIEF.md
# Page Write Buffer and Timer

This block gathers the data bytes of one bus write transaction into a 16-byte staging buffer. Each slot carries a flag that records whether it was loaded. The bus target marks the start of a transaction, loads the starting word address, hands over data bytes one at a time, and signals the stop. The address selects one of 16 pages of 16 bytes. The upper four address bits fix the page. The lower four bits step through the page for each byte and wrap at the page end, so a long burst overwrites bytes that were loaded earlier.

At a stop that follows at least one data byte, the block starts an internal write cycle. In the first cycle of that window, every loaded byte whose address is allowed by the per-byte write-allow vector is copied into a 256 x 8 register array. A busy flag then stays high for a programmable number of clock cycles, whether or not any byte was allowed. While busy is high, all transaction inputs are ignored. The array can be read at any time through a combinational read port.

Top module: `pwb_top`

## Requirements
- R1: After synchronous reset, `busy` is 0 and every array location reads 0x00.
- R2: Each accepted data byte goes to the current offset within the page (address bits [3:0]). Only that offset advances by one per byte. The page (address bits [7:4]) stays as loaded for the whole transaction.
- R3: After offset 15 the next byte goes to offset 0 of the same page. When more than 16 bytes arrive, the later byte replaces the earlier one at that offset.
- R4: Only loaded offsets are written at commit. Array bytes that were not loaded in the transaction keep their previous contents.
- R5: A stop sampled while idle, with at least one loaded byte, raises `busy` at the next clock edge. `busy` then stays high for exactly `WAIT_CYC` consecutive cycles.
- R6: The commit happens in the first busy cycle, so new data is readable while `busy` is still high.
- R7: A loaded byte whose bit in `wr_allow` (bit i for offset i, sampled in the commit cycle) is 0 leaves its array byte unchanged. The busy window keeps its full length even when no byte is allowed.
- R8: A stop with no loaded byte since the last start starts no write cycle: `busy` stays 0 and the array does not change.
- R9: A start clears all loaded-byte flags, so bytes loaded before it are never committed.
- R10: While `busy` is high, start, address load, data strobes and stop have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Start of a bus transaction, one-cycle pulse |
| addr_load | input | 1 | Load word address strobe |
| addr_in | input | 8 | Word address: page in [7:4], offset in [3:0] |
| byte_stb | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| stop_in | input | 1 | Stop condition pulse |
| wr_allow | input | 16 | Write allow for each offset of the current page |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two situations are hard to reach from the ports. The first is a burst long enough to wrap the offset past the page end. The bench reaches it with a sweep over all 16 pages, where the start offset equals the page index and the burst length grows with the page index, so the last pages wrap. The second is activity that arrives during the busy window. The bench injects a full transaction while `busy` is high. It then issues a bare stop once idle, which would start a cycle only if a stray byte had been recorded. A separate case restarts a transaction in mid-load and probes the array while `busy` is still high, to show that the commit comes early and that the abandoned bytes are dropped.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int DW    = 8;
    localparam int OFS_W = 4;
    localparam int PG_W  = 4;
    localparam int AW    = PG_W + OFS_W;
    localparam int PB    = 1 << OFS_W;
    localparam int DEPTH = 1 << AW;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic [PG_W-1:0]  page;
        logic [OFS_W-1:0] ofs;
    } waddr_t;

    typedef enum logic [1:0] {
        TM_IDLE   = 2'd0,
        TM_COMMIT = 2'd1,
        TM_HOLD   = 2'd2
    } tm_state_e;

    function automatic logic [OFS_W-1:0] step_ofs(input logic [OFS_W-1:0] o);
        return o + 1'b1;
    endfunction

    function automatic logic [AW-1:0] join_addr(input logic [PG_W-1:0] pg, input int unsigned o);
        return {pg, o[OFS_W-1:0]};
    endfunction
endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer
    import pwb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold,
    input  logic                  clr,
    input  logic                  start,
    input  logic                  addr_ld,
    input  logic [AW-1:0]         addr,
    input  logic                  stb,
    input  byte_t                 din,
    output waddr_t                cur,
    output logic [PB-1:0]         mask,
    output logic [PB-1:0][DW-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            mask <= '0;
            data <= '0;
        end else if (clr) begin
            mask <= '0;
        end else if (!hold) begin
            if (start) begin
                mask <= '0;
            end else if (addr_ld) begin
                cur <= waddr_t'(addr);
            end else if (stb) begin
                data[cur.ofs] <= din;
                mask[cur.ofs] <= 1'b1;
                cur.ofs       <= step_ofs(cur.ofs);
            end
        end
    end

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst) (stb && !hold && !clr && !start && !addr_ld) |=> $stable(cur.page)); // R2
    AST_OFS_STEP: assert property (@(posedge clk) disable iff (rst) (stb && !hold && !clr && !start && !addr_ld) |=> cur.ofs == OFS_W'($past(cur.ofs) + 1)); // R3
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) (start && !hold) |=> mask == '0); // R9
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst) (hold && !clr) |=> $stable(mask) && $stable(cur)); // R10
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer
    import pwb_pkg::*;
#(
    parameter int WAIT_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic commit_en
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    tm_state_e     st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= TM_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                TM_IDLE: if (go) begin
                    st  <= TM_COMMIT;
                    cnt <= CW'(WAIT_CYC - 1);
                end
                TM_COMMIT, TM_HOLD: begin
                    if (cnt == '0) st <= TM_IDLE;
                    else begin
                        st  <= TM_HOLD;
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= TM_IDLE;
            endcase
        end
    end

    assign busy      = (st != TM_IDLE);
    assign commit_en = (st == TM_COMMIT);

    AST_GO_BUSY: assert property (@(posedge clk) disable iff (rst) (go && !busy) |=> busy && commit_en); // R5
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) busy |-> (int'(cnt) < WAIT_CYC)); // R5
    AST_COMMIT_ONCE: assert property (@(posedge clk) disable iff (rst) commit_en |=> !commit_en); // R6
endmodule

// File: rtl/pwb_array.sv
module pwb_array
    import pwb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  logic [PG_W-1:0]       page,
    input  logic [PB-1:0]         mask,
    input  logic [PB-1:0][DW-1:0] data,
    input  logic [PB-1:0]         allow,
    input  logic [AW-1:0]         rd_addr,
    output byte_t                 rd_data
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PB; i++) begin
                if (mask[i] && allow[i]) mem[join_addr(page, i)] <= data[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

    logic          rd_hit;
    logic [OFS_W-1:0] rd_ofs;
    assign rd_ofs = rd_addr[OFS_W-1:0];
    assign rd_hit = (rd_addr[AW-1:OFS_W] == page);

    AST_PROT_KEEP: assert property (@(posedge clk) disable iff (rst) (commit && rd_hit && !(mask[rd_ofs] && allow[rd_ofs])) |=> (!$stable(rd_addr) || $stable(rd_data))); // R7
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst) !commit |=> (!$stable(rd_addr) || $stable(rd_data))); // R4
endmodule

// File: rtl/pwb_top.sv
module pwb_top
    import pwb_pkg::*;
#(
    parameter int WAIT_CYC = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        txn_start,
    input  logic        addr_load,
    input  logic [7:0]  addr_in,
    input  logic        byte_stb,
    input  logic [7:0]  byte_in,
    input  logic        stop_in,
    input  logic [15:0] wr_allow,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        busy
);
    waddr_t                cur;
    logic [PB-1:0]         mask;
    logic [PB-1:0][DW-1:0] data;
    logic                  commit_en;
    logic                  go;

    assign go = stop_in && !busy && (mask != '0);

    pwb_buffer u_buf (
        .clk(clk), .rst(rst), .hold(busy), .clr(commit_en),
        .start(txn_start), .addr_ld(addr_load), .addr(addr_in),
        .stb(byte_stb), .din(byte_in),
        .cur(cur), .mask(mask), .data(data)
    );

    pwb_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
        .clk(clk), .rst(rst), .go(go), .busy(busy), .commit_en(commit_en)
    );

    pwb_array u_arr (
        .clk(clk), .rst(rst), .commit(commit_en), .page(cur.page),
        .mask(mask), .data(data), .allow(wr_allow),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (rst) (stop_in && !busy && mask == '0) |=> !busy); // R8
    AST_STOP_STARTS: assert property (@(posedge clk) disable iff (rst) (stop_in && !busy && mask != '0) |=> busy); // R5
endmodule

// File: tb/sim_pwb_top.sv
module sim_pwb_top;
    localparam int WAIT = 12;

    logic        clk = 0;
    logic        rst = 1;
    logic        txn_start = 0, addr_load = 0, byte_stb = 0, stop_in = 0;
    logic [7:0]  addr_in = 0, byte_in = 0, rd_addr = 0;
    logic [15:0] wr_allow = 16'hFFFF;
    logic [7:0]  rd_data;
    logic        busy;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [7:0]  exp_mem [256];
    logic [15:0] bm;
    logic [7:0]  bd [16];
    logic [3:0]  pg, of;

    pwb_top #(.WAIT_CYC(WAIT)) u0 (
        .clk(clk), .rst(rst), .txn_start(txn_start), .addr_load(addr_load),
        .addr_in(addr_in), .byte_stb(byte_stb), .byte_in(byte_in),
        .stop_in(stop_in), .wr_allow(wr_allow), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_start();
        @(negedge clk); txn_start = 1;
        @(negedge clk); txn_start = 0;
        bm = '0;
    endtask

    task automatic t_addr(input logic [7:0] a);
        @(negedge clk); addr_load = 1; addr_in = a;
        @(negedge clk); addr_load = 0;
        pg = a[7:4]; of = a[3:0];
    endtask

    task automatic t_byte(input logic [7:0] d);
        @(negedge clk); byte_stb = 1; byte_in = d;
        @(negedge clk); byte_stb = 0;
        bd[of] = d; bm[of] = 1'b1; of = of + 1'b1;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a); #0.1;
            chk(req, rd_data, exp_mem[a]);
        end
    endtask

    // stop; expect busy for WAIT cycles if bytes are loaded, then update model
    task automatic t_stop(input bit expb);
        int n;
        @(negedge clk); stop_in = 1;
        @(negedge clk); stop_in = 0;
        if (expb) begin
            chk("R5 busy rise", busy, 1);
            n = 1;
            for (int g = 0; g < 1000; g++) begin
                @(negedge clk);
                if (busy) n++; else break;
            end
            chk("R5 R7 busy length", n, WAIT);
            for (int i = 0; i < 16; i++)
                if (bm[i] && wr_allow[i]) exp_mem[{pg, 4'(i)}] = bd[i];
            bm = '0;
        end else begin
            for (int g = 0; g < 3; g++) begin
                chk("R8 no busy", busy, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) exp_mem[a] = 8'h00;
        bm = '0; pg = 0; of = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        sweep("R1");

        // R2 R3 R4 R7: sweep every page, two passes, wraps when length > 16
        for (int pass = 0; pass < 2; pass++) begin
            for (int p = 0; p < 16; p++) begin
                int len;
                len = (pass == 0) ? p + 3 : (p % 5) + 1;
                wr_allow = (p % 4 == 3) ? 16'h0000 : (p % 4 == 2) ? 16'h00FF : 16'hFFFF;
                t_start();
                t_addr(8'(p * 16 + ((p + pass * 7) % 16)));
                for (int k = 0; k < len; k++) t_byte(8'(p * 37 + k * 11 + 5 + pass * 3));
                t_stop(1);
                sweep("R2 R3 R4 R7");
            end
        end
        wr_allow = 16'hFFFF;

        // R8: stop after only an address
        t_start();
        t_addr(8'h23);
        t_stop(0);
        sweep("R8");

        // R9 and R6: restart drops earlier bytes; commit visible while busy
        t_start();
        t_addr(8'h40);
        t_byte(8'hA1); t_byte(8'hA2); t_byte(8'hA3);
        t_start();
        t_addr(8'h45);
        t_byte(8'h5D);
        rd_addr = 8'h45;
        @(negedge clk); stop_in = 1;
        @(negedge clk); stop_in = 0;
        chk("R5 busy rise", busy, 1);
        @(negedge clk);
        chk("R6 busy still high", busy, 1);
        chk("R6 early commit", rd_data, 8'h5D);
        for (int g = 0; g < 1000; g++) begin
            if (!busy) break;
            @(negedge clk);
        end
        exp_mem[8'h45] = 8'h5D;
        bm = '0;
        sweep("R9");

        // R10: activity during busy is ignored
        t_start();
        t_addr(8'h80);
        t_byte(8'h11);
        @(negedge clk); stop_in = 1;
        @(negedge clk); stop_in = 0;
        exp_mem[8'h80] = 8'h11;
        @(negedge clk); txn_start = 1;
        @(negedge clk); txn_start = 0; addr_load = 1; addr_in = 8'h90;
        @(negedge clk); addr_load = 0; byte_stb = 1; byte_in = 8'hEE;
        @(negedge clk); byte_in = 8'hEF;
        @(negedge clk); byte_stb = 0; stop_in = 1;
        @(negedge clk); stop_in = 0;
        chk("R10 still busy", busy, 1);
        for (int g = 0; g < 1000; g++) begin
            if (!busy) break;
            @(negedge clk);
        end
        bm = '0;
        // bare stop: would start a cycle only if a byte had been recorded while busy
        t_stop(0);
        sweep("R10");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule